// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

A clocked static memory with a word of two bytes, meant to stand in for an external burst SRAM or to serve as a local buffer that keeps the same pin behaviour. Every control input except the output enable is sampled on the rising clock edge. An access begins when one of two address strobes is sampled active. The processor strobe only counts when the main chip select is active. The controller strobe always counts. On a strobe cycle the three chip selects decide between two outcomes: the device is selected and the address is loaded, or the device drops into standby.

Once an address is loaded, the following cycles continue the burst. An advance input steps the two low address bits. The step order is linear or interleaved, chosen by a static pin. Whether a cycle reads or writes depends on three levels of write enable: a global write, then a byte-write gate, then one enable per byte. A cycle loaded by the processor strobe is always a read. Read data leaves the array one edge after the access (flow-through) or two edges after it (pipelined), chosen by a static pin. The asynchronous output enable then gates the drive flag.

The tristate pad itself stays outside the core. `drive_o` tells the pad when to drive `rdata_o`. A sleep input freezes the core and keeps its contents.

Top module: `sbsram_core`

## Requirements
- R1: After reset no burst is active and `drive_o` stays low until a strobe selects the device.
- R2: A cycle with `lds_ctrl_n` low and all three selects active (`cs_main_n`=0, `cs_pos`=1, `cs_neg_n`=0) loads `addr_i` and accesses that address in the same cycle.
- R3: With `cs_main_n` high, a low `lds_proc_n` is ignored. A running burst continues unchanged.
- R4: A cycle loaded by `lds_proc_n` (with `cs_main_n` low) is a read, whatever the write enables are. Memory is not changed in that cycle.
- R5: A strobe cycle with any select inactive deselects the device. No write happens, and `drive_o` is low in the slot where that cycle's read data would have appeared.
- R6: On cycles with neither strobe counting, the three selects have no effect.
- R7: `wr_all_n` low writes both bytes of `wdata_i`, whatever `wr_byte_n` and `byte_wr_n` are.
- R8: With `wr_all_n` high and `wr_byte_n` low, each byte b with `byte_wr_n[b]` low is written (bit 0 is bits 7:0, bit 1 is bits 15:8). Other bytes keep their value. With no byte enable low, the cycle is a read.
- R9: With `wr_all_n` and `wr_byte_n` both high, the cycle is a read.
- R10: On a burst cycle with no strobe, `adv_n` low steps the burst count by one. The two low address bits become base+count mod 4 when `lin_mode`=1, and base XOR count when `lin_mode`=0. With `adv_n` high, the current address is repeated.
- R11: With `flow_n`=0, read data and `drive_o` appear after the clock edge that samples the access. With `flow_n`=1 they appear one edge later.
- R12: `drive_o` is high only while `out_en_n` is low, and `out_en_n` acts without a clock.
- R13: While `sleep_i` is high, no access takes place and the load and burst state hold. Stored data is kept, and that cycle's slot shows `drive_o` low.
- R14: Write data is taken from `wdata_i` at the same edge that samples the write decision, including on burst continuation cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | ADDR_W | Address loaded on a strobe cycle |
| wdata_i | input | NBYTES*BYTE_W | Write data |
| lds_proc_n | input | 1 | Processor address strobe, active low |
| lds_ctrl_n | input | 1 | Controller address strobe, active low |
| cs_main_n | input | 1 | Main chip select, active low |
| cs_pos | input | 1 | Secondary select, active high |
| cs_neg_n | input | 1 | Secondary select, active low |
| adv_n | input | 1 | Burst advance, active low |
| wr_all_n | input | 1 | Global write of all bytes, active low |
| wr_byte_n | input | 1 | Gate for per-byte enables, active low |
| byte_wr_n | input | NBYTES | Per-byte write enables, active low |
| out_en_n | input | 1 | Asynchronous output enable, active low |
| flow_n | input | 1 | Static: 0 flow-through, 1 pipelined |
| lin_mode | input | 1 | Static: 1 linear, 0 interleaved burst order |
| sleep_i | input | 1 | Low-power hold, data retained |
| rdata_o | output | NBYTES*BYTE_W | Read data |
| drive_o | output | 1 | Pad drive enable for rdata_o |

## Verification
The bench targets the strobe qualification. A design that let the processor strobe through with the main select high would jump to the new address. A design that honoured writes on a processor-loaded cycle would corrupt the word it was asked to read. The write-enable priority is tested with the global write against idle byte enables, a partial byte write, and a byte-write gate with no byte chosen. A wrong priority shows up as a missing or extra changed byte. Burst wrap from base 3 in linear order and from base 1 in interleaved order, deselect timing in both latency modes, and sleep cycles are all compared against a reference memory. An off-by-one edge or a lost freeze shows up as data in the wrong slot.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;
  typedef enum logic [1:0] {
    CYC_IDLE  = 2'd0,
    CYC_READ  = 2'd1,
    CYC_WRITE = 2'd2
  } cyc_kind_e;
endpackage

// File: rtl/sbsram_burst_gen.sv
module sbsram_burst_gen #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [BURST_W-1:0] count_i,
  input  logic               lin_i,
  output logic [ADDR_W-1:0]  addr_o
);
  logic [BURST_W-1:0] low_lin;
  logic [BURST_W-1:0] low_ilv;

  always_comb begin
    low_lin = base_i[BURST_W-1:0] + count_i;
    low_ilv = base_i[BURST_W-1:0] ^ count_i;
  end

  generate
    if (ADDR_W > BURST_W) begin : g_upper
      assign addr_o = {base_i[ADDR_W-1:BURST_W], (lin_i ? low_lin : low_ilv)};
    end else begin : g_flat
      assign addr_o = lin_i ? low_lin : low_ilv;
    end
  endgenerate
endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
  import sbsram_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int NBYTES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              lds_proc_n,
  input  logic              lds_ctrl_n,
  input  logic              cs_main_n,
  input  logic              cs_pos,
  input  logic              cs_neg_n,
  input  logic              adv_n,
  input  logic              wr_all_n,
  input  logic              wr_byte_n,
  input  logic [NBYTES-1:0] byte_wr_n,
  input  logic              lin_mode,
  input  logic              sleep_i,
  output logic [ADDR_W-1:0] acc_addr_o,
  output logic [NBYTES-1:0] wr_be_o,
  output logic              rd_req_o
);
  logic               active_q;
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] cnt_q;
  logic [BURST_W-1:0] cnt_next;
  logic [ADDR_W-1:0]  gen_addr;
  logic               proc_go, ctrl_go, strobe, sel_all;
  logic [NBYTES-1:0]  be_req;
  cyc_kind_e          kind;

  always_comb begin
    proc_go  = !lds_proc_n && !cs_main_n;
    ctrl_go  = !lds_ctrl_n;
    strobe   = proc_go || ctrl_go;
    sel_all  = !cs_main_n && cs_pos && !cs_neg_n;
    cnt_next = adv_n ? cnt_q : cnt_q + 1'b1;
  end

  sbsram_burst_gen #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_gen (
    .base_i (base_q),
    .count_i(cnt_next),
    .lin_i  (lin_mode),
    .addr_o (gen_addr)
  );

  // three-level write priority
  always_comb begin
    if (!wr_all_n)       be_req = '1;
    else if (!wr_byte_n) be_req = ~byte_wr_n;
    else                 be_req = '0;
  end

  always_comb begin
    kind       = CYC_IDLE;
    acc_addr_o = strobe ? addr_i : gen_addr;
    if (sleep_i) begin
      kind = CYC_IDLE;
    end else if (strobe) begin
      if (sel_all) begin
        if (proc_go)          kind = CYC_READ;
        else if (|be_req)     kind = CYC_WRITE;
        else                  kind = CYC_READ;
      end
    end else if (active_q) begin
      kind = (|be_req) ? CYC_WRITE : CYC_READ;
    end
  end

  assign wr_be_o  = (kind == CYC_WRITE) ? be_req : '0;
  assign rd_req_o = (kind == CYC_READ);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      base_q   <= '0;
      cnt_q    <= '0;
    end else if (!sleep_i) begin
      if (strobe) begin
        active_q <= sel_all;
        base_q   <= addr_i;
        cnt_q    <= '0;
      end else if (active_q) begin
        cnt_q <= cnt_next;
      end
    end
  end

  assert_sleep_blocks_write_R13: assert property (@(posedge clk) disable iff (rst)
    sleep_i |-> (wr_be_o == '0 && !rd_req_o));

  assert_proc_load_read_R4: assert property (@(posedge clk) disable iff (rst)
    (!lds_proc_n && !cs_main_n) |-> (wr_be_o == '0));

  assert_no_gate_no_write_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_all_n && wr_byte_n) |-> (wr_be_o == '0));

  assert_sleep_holds_base_R13: assert property (@(posedge clk) disable iff (rst)
    sleep_i |=> $stable(base_q));
endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
  parameter int ADDR_W = 8,
  parameter int NBYTES = 2,
  parameter int BYTE_W = 8
) (
  input  logic                     clk,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NBYTES-1:0]        we_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  generate
    for (genvar b = 0; b < NBYTES; b++) begin : g_lane
      logic [BYTE_W-1:0] mem [DEPTH];
      always_ff @(posedge clk) begin
        if (we_i[b]) mem[addr_i] <= wdata_i[b*BYTE_W +: BYTE_W];
        rdata_o[b*BYTE_W +: BYTE_W] <= mem[addr_i];
      end
    end
  endgenerate
endmodule

// File: rtl/sbsram_rdpipe.sv
module sbsram_rdpipe #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_req_i,
  input  logic          flow_n,
  input  logic          out_en_n,
  input  logic [DW-1:0] ram_q_i,
  output logic [DW-1:0] rdata_o,
  output logic          drive_o
);
  logic          v1_q, v2_q;
  logic [DW-1:0] d2_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else begin
      v1_q <= rd_req_i;
      v2_q <= v1_q;
    end
  end

  always_ff @(posedge clk) d2_q <= ram_q_i;

  assign rdata_o = flow_n ? d2_q : ram_q_i;
  assign drive_o = (flow_n ? v2_q : v1_q) && !out_en_n;
endmodule

// File: rtl/sbsram_core.sv
module sbsram_core #(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2,
  parameter int NBYTES  = 2,
  parameter int BYTE_W  = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [ADDR_W-1:0]        addr_i,
  input  logic [NBYTES*BYTE_W-1:0] wdata_i,
  input  logic                     lds_proc_n,
  input  logic                     lds_ctrl_n,
  input  logic                     cs_main_n,
  input  logic                     cs_pos,
  input  logic                     cs_neg_n,
  input  logic                     adv_n,
  input  logic                     wr_all_n,
  input  logic                     wr_byte_n,
  input  logic [NBYTES-1:0]        byte_wr_n,
  input  logic                     out_en_n,
  input  logic                     flow_n,
  input  logic                     lin_mode,
  input  logic                     sleep_i,
  output logic [NBYTES*BYTE_W-1:0] rdata_o,
  output logic                     drive_o
);
  localparam int DW = NBYTES * BYTE_W;

  logic [ADDR_W-1:0] acc_addr;
  logic [NBYTES-1:0] wr_be;
  logic              rd_req;
  logic [DW-1:0]     ram_q;

  sbsram_ctrl #(.ADDR_W(ADDR_W), .BURST_W(BURST_W), .NBYTES(NBYTES)) u_ctrl (
    .clk, .rst, .addr_i, .lds_proc_n, .lds_ctrl_n, .cs_main_n, .cs_pos, .cs_neg_n,
    .adv_n, .wr_all_n, .wr_byte_n, .byte_wr_n, .lin_mode, .sleep_i,
    .acc_addr_o(acc_addr), .wr_be_o(wr_be), .rd_req_o(rd_req)
  );

  sbsram_array #(.ADDR_W(ADDR_W), .NBYTES(NBYTES), .BYTE_W(BYTE_W)) u_array (
    .clk, .addr_i(acc_addr), .we_i(wr_be), .wdata_i, .rdata_o(ram_q)
  );

  sbsram_rdpipe #(.DW(DW)) u_pipe (
    .clk, .rst, .rd_req_i(rd_req), .flow_n, .out_en_n, .ram_q_i(ram_q),
    .rdata_o, .drive_o
  );

  assert_flow_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (!flow_n && drive_o) |-> $past(rd_req));

  assert_pipe_latency_R11: assert property (@(posedge clk) disable iff (rst)
    (flow_n && drive_o) |-> $past(rd_req, 2));

  assert_deselect_off_R5: assert property (@(posedge clk) disable iff (rst)
    (!sleep_i && !lds_ctrl_n && !cs_pos && !flow_n) |=> !drive_o);

  assert_deselect_no_write_R5: assert property (@(posedge clk) disable iff (rst)
    (!lds_ctrl_n && cs_neg_n) |-> (wr_be == '0));
endmodule

// File: tb/sbsram_core_tb.sv
module sbsram_core_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic lds_proc_n = 1, lds_ctrl_n = 1, cs_main_n = 0, cs_pos = 1, cs_neg_n = 0;
  logic adv_n = 1, wr_all_n = 1, wr_byte_n = 1;
  logic [1:0] byte_wr_n = 2'b11;
  logic out_en_n = 0, flow_n = 0, lin_mode = 1, sleep_i = 0;
  logic [15:0] rdata_o;
  logic drive_o;

  sbsram_core u_dut (
    .clk, .rst, .addr_i, .wdata_i, .lds_proc_n, .lds_ctrl_n, .cs_main_n, .cs_pos,
    .cs_neg_n, .adv_n, .wr_all_n, .wr_byte_n, .byte_wr_n, .out_en_n, .flow_n,
    .lin_mode, .sleep_i, .rdata_o, .drive_o
  );

  typedef struct { int due; bit drv; logic [15:0] d; string tag; } exp_t;
  exp_t q[$];
  int total = 0, fails = 0, edge_n = 0;
  bit done = 0;

  // reference state
  logic [15:0] m_mem [256];
  bit m_active = 0;
  logic [7:0] m_base = '0;
  logic [1:0] m_cnt = '0;

  function automatic logic [7:0] gen(input logic [7:0] b, input logic [1:0] c, input bit lin);
    logic [1:0] lo;
    lo = lin ? (b[1:0] + c) : (b[1:0] ^ c);
    return {b[7:2], lo};
  endfunction

  // driver step: model the upcoming edge, optionally push expectation, wait one cycle
  task automatic tick(input bit chk, input string tag);
    bit proc_go, ctrl_go, sel, rd, wr;
    logic [1:0] be, nc;
    logic [7:0] a;
    exp_t e;
    proc_go = !lds_proc_n && !cs_main_n;
    ctrl_go = !lds_ctrl_n;
    sel = !cs_main_n && cs_pos && !cs_neg_n;
    be = !wr_all_n ? 2'b11 : (!wr_byte_n ? ~byte_wr_n : 2'b00);
    rd = 0; wr = 0; a = addr_i;
    nc = adv_n ? m_cnt : m_cnt + 2'd1;
    if (sleep_i) begin
    end else if (proc_go || ctrl_go) begin
      if (sel) begin
        if (proc_go || be == 2'b00) rd = 1; else wr = 1;
      end
      m_active = sel; m_base = addr_i; m_cnt = '0;
    end else if (m_active) begin
      a = gen(m_base, nc, lin_mode);
      if (be == 2'b00) rd = 1; else wr = 1;
      m_cnt = nc;
    end
    if (chk) begin
      e.due = edge_n + (flow_n ? 2 : 1);
      e.drv = rd && !out_en_n;
      e.d   = rd ? m_mem[a] : 16'h0;
      e.tag = tag;
      q.push_back(e);
    end
    if (wr) begin
      if (be[0]) m_mem[a][7:0]  = wdata_i[7:0];
      if (be[1]) m_mem[a][15:8] = wdata_i[15:8];
    end
    @(negedge clk);
  endtask

  task automatic push_off(input int due, input string tag);
    exp_t e;
    e.due = due; e.drv = 0; e.d = 16'h0; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic idle_pins();
    lds_proc_n = 1; lds_ctrl_n = 1; cs_main_n = 0; cs_pos = 1; cs_neg_n = 0;
    adv_n = 1; wr_all_n = 1; wr_byte_n = 1; byte_wr_n = 2'b11; sleep_i = 0;
  endtask

  task automatic ctrl_load(input logic [7:0] a);
    idle_pins(); lds_ctrl_n = 0; addr_i = a;
  endtask

  task automatic deselect();
    idle_pins(); lds_ctrl_n = 0; cs_pos = 0;
  endtask

  // monitor: compares outputs one time unit after each rising edge
  always @(posedge clk) begin
    edge_n++;
    #1;
    while (q.size() > 0 && q[0].due <= edge_n) begin
      exp_t e;
      e = q.pop_front();
      total++;
      if (e.due != edge_n || drive_o !== e.drv || (e.drv && rdata_o !== e.d)) begin
        fails++;
        $display("FAIL %s: actual drive=%b data=%h, expected drive=%b data=%h",
                 e.tag, drive_o, rdata_o, e.drv, e.d);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) m_mem[i] = 16'hxxxx;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    total++;
    if (drive_o !== 1'b0) begin
      fails++; $display("FAIL R1: actual drive=%b expected drive=0", drive_o);
    end
    idle_pins(); tick(1, "R1 no burst after reset");

    // R7: global write with byte enables idle
    for (int i = 0; i < 8; i++) begin
      ctrl_load(8'h20 + 8'(i)); wr_all_n = 0; wdata_i = 16'hA100 + 16'(i * 16'h0111);
      tick(0, "");
    end
    for (int i = 0; i < 8; i++) begin
      ctrl_load(8'h20 + 8'(i)); tick(1, "R2 R7 read back");
    end

    // R8: low byte only
    ctrl_load(8'h20); wr_byte_n = 0; byte_wr_n = 2'b10; wdata_i = 16'h5A5A; tick(0, "");
    ctrl_load(8'h20); tick(1, "R8 partial byte");
    // R8: gate low, no byte chosen -> read
    ctrl_load(8'h21); wr_byte_n = 0; byte_wr_n = 2'b11; wdata_i = 16'hFFFF; tick(1, "R8 no byte read");
    // R9: gate high with byte enables low -> read
    ctrl_load(8'h21); byte_wr_n = 2'b00; wdata_i = 16'hEEEE; tick(1, "R9 gate high read");
    ctrl_load(8'h21); tick(1, "R9 unchanged");

    // R14: burst write, data captured on each edge
    ctrl_load(8'h24); wr_all_n = 0; wdata_i = 16'h1234; tick(0, "");
    idle_pins(); adv_n = 0; wr_all_n = 0; wdata_i = 16'h5678; tick(0, "");
    ctrl_load(8'h24); tick(1, "R14 first word");
    ctrl_load(8'h25); tick(1, "R14 burst word");

    // R4: processor-loaded cycle ignores writes
    idle_pins(); lds_proc_n = 0; addr_i = 8'h22; wr_all_n = 0; wdata_i = 16'h0000;
    tick(1, "R4 proc load reads");
    ctrl_load(8'h22); tick(1, "R4 unchanged");

    // R3 / R6
    ctrl_load(8'h23); tick(1, "R3 base read");
    idle_pins(); lds_proc_n = 0; cs_main_n = 1; addr_i = 8'h26; tick(1, "R3 proc ignored");
    idle_pins(); cs_pos = 0; cs_neg_n = 1; tick(1, "R6 selects ignored");

    // R5: deselect with write attempt
    deselect(); addr_i = 8'h23; wr_all_n = 0; wdata_i = 16'hDEAD; tick(1, "R5 deselect off");
    idle_pins(); tick(1, "R5 stays off");
    ctrl_load(8'h23); tick(1, "R5 no write");

    // R10: linear from base 3, then interleaved from base 1
    lin_mode = 1;
    ctrl_load(8'h27); tick(1, "R10 lin 0");
    for (int i = 0; i < 3; i++) begin idle_pins(); adv_n = 0; tick(1, "R10 lin step"); end
    idle_pins(); tick(1, "R10 hold");
    lin_mode = 0;
    ctrl_load(8'h25); tick(1, "R10 ilv 0");
    for (int i = 0; i < 3; i++) begin idle_pins(); adv_n = 0; tick(1, "R10 ilv step"); end
    lin_mode = 1;

    // R12: output enable high
    out_en_n = 1;
    ctrl_load(8'h26); tick(1, "R12 oe high");
    idle_pins(); tick(1, "R12 oe high");
    @(negedge clk);
    out_en_n = 0;
    idle_pins(); tick(1, "R12 oe low");

    // R13: sleep blocks write and holds state
    ctrl_load(8'h20); tick(1, "R13 before");
    idle_pins(); sleep_i = 1; lds_ctrl_n = 0; addr_i = 8'h21; wr_all_n = 0; wdata_i = 16'h0;
    tick(1, "R13 sleeping");
    idle_pins(); tick(1, "R13 state held");
    ctrl_load(8'h21); tick(1, "R13 data kept");

    // R11: pipelined mode
    deselect(); tick(0, "");
    idle_pins(); tick(0, ""); tick(0, ""); tick(0, "");
    flow_n = 1;
    idle_pins(); tick(0, "");
    ctrl_load(8'h21); push_off(edge_n + 1, "R11 pipe not early"); tick(1, "R11 pipe load");
    for (int i = 0; i < 3; i++) begin idle_pins(); adv_n = 0; tick(1, "R11 pipe burst"); end
    deselect(); tick(1, "R5 pipe deselect");
    idle_pins(); tick(1, "R5 pipe off");

    idle_pins();
    repeat (4) @(negedge clk);
    total++;
    if (q.size() != 0) begin
      fails++; $display("FAIL R11: actual pending=%0d expected pending=0", q.size());
    end
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule